// File: doc/BRIEF.md
# NAND card control and data port

This block sits between a simple register request bus and the pins of a raw 8-bit NAND card. Software steers the card's latch and enable lines through a control register, moves bytes through a data register, and polls a read-only status register for the card's busy, presence and write-protect state. Every NAND bus cycle the block generates has fixed timing: the write or read strobe is held low for two clocks and then high for two clocks.

The data register has two meanings. Normally, a byte access runs one NAND cycle and a 32-bit access runs four, with the least significant byte first. When the ECC access bit of the control register is set, a 32-bit read of the data register runs no bus cycle. It returns the word that an external ECC engine presents, and it pulses a pop strobe so that the engine can move on to its next word.

Requests use a hold-until-ready handshake. The host keeps `req` and its fields steady until `ready` pulses for one clock, and it drops `req` after that pulse. Register and ECC accesses complete on the first clock edge. A data transfer holds `ready` low until its last strobe high phase has ended.

Top module: `nand_port`

## Requirements
- R1: After reset, `ready` and `ecc_pop` are 0, both strobes are high, `nand_io_oe` is 0, `nand_cle` and `nand_ale` are 0, `nand_ce_n` is 1, `nand_wp_n` is 0, and a read of the control register (address 1) returns 0.
- R2: A write to the control register (address 1) sets the outputs from the written bits, and a read returns the stored byte. The bit map is: bit 0 drives `nand_cle`, bit 1 drives `nand_ale`, bit 2 drives `card_led`, bit 4 drives `nand_ce_n` low, bit 5 drives `ecc_en`, bit 6 is ECC access, and bit 7 drives `nand_wp_n` high. Bit 3 is never stored.
- R3: A control write with bit 3 (0x08) set clears every control bit, whatever the other written bits are. As a result `nand_ce_n` is 1, `nand_wp_n` is 0, and a readback returns 0.
- R4: A byte write to the data register (address 0, `req_word` = 0) runs exactly one write cycle. That cycle drives `req_wdata[7:0]` with `nand_io_oe` high and holds `nand_we_n` low for 2 clocks and high for 2 clocks. `ready` rises after the 5th rising edge counted from the first edge that sees `req`.
- R5: A 32-bit write to the data register runs four write cycles that carry bytes 0, 1, 2 and 3 of `req_wdata`, least significant first. `ready` rises after the 17th edge.
- R6: A byte read of the data register runs one read cycle with `nand_re_n` low for 2 clocks and `nand_io_oe` low. `rdata[7:0]` holds the card byte sampled in the strobe's last low clock, and `rdata[31:8]` is 0.
- R7: A 32-bit read of the data register runs four read cycles. The first byte read goes into `rdata[7:0]` and the fourth into `rdata[31:24]`.
- R8: While control bit 6 is set, a 32-bit data read returns `ecc_word` after the first edge, pulses `ecc_pop` for one clock and runs no strobe. A byte data read in this mode still runs one read cycle.
- R9: A read of the status register (address 2) returns `card_busy` in bit 7, `card_present` in bit 2, `card_wp` in bit 1, and 0 in every other bit.
- R10: `ready` is high for exactly one clock per request. It stays low while a transfer is in progress, and the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request, held until ready |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | 0 data, 1 control, 2 status |
| req_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| req_wdata | input | 32 | Write data |
| ready | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Read data, valid while ready is high |
| nand_io_out | output | 8 | Card data bus, out |
| nand_io_oe | output | 1 | Card data bus drive enable |
| nand_io_in | input | 8 | Card data bus, in |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| card_led | output | 1 | Activity indicator |
| card_busy | input | 1 | Card busy (ready/busy line) |
| card_present | input | 1 | Card detect |
| card_wp | input | 1 | Card write-protect switch |
| ecc_en | output | 1 | ECC engine enable |
| ecc_word | input | 32 | ECC result word from the engine |
| ecc_pop | output | 1 | Pulse: ECC word consumed |

## Verification
The data register is exercised with byte writes, word writes, byte reads and word reads. The data values are random, so every byte lane carries a distinct value. This separates a correct least-significant-first order from a reversed or repeated lane, and it shows whether unused upper read bits are left stale. Directed cases cover the rest. Word reads with ECC access set must return the engine word with no strobe. Byte reads in the same mode must still strobe, which tells a full-mode decode apart from a width-aware one. Control writes with and without the reset bit are compared, as are status reads under two input patterns.

// File: rtl/nand_port_pkg.sv
`timescale 1ns/1ps
package nand_port_pkg;
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Packed MSB first so that each field sits at its control bit position.
  typedef struct packed {
    logic wr_en;      // bit 7
    logic ecc_acc;    // bit 6
    logic ecc_on;     // bit 5
    logic card_on;    // bit 4
    logic clr;        // bit 3, never stored
    logic act;        // bit 2
    logic addr_latch; // bit 1
    logic cmd_latch;  // bit 0
  } ctrl_t;

  localparam int CTRL_CLR_BIT = 3;
endpackage

// File: rtl/nand_ctl_regs.sv
`timescale 1ns/1ps
module nand_ctl_regs
  import nand_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       busy_i,
  input  logic       present_i,
  input  logic       wp_i,
  output ctrl_t      ctrl_q,
  output logic [7:0] stat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr) begin
      if (wdata[CTRL_CLR_BIT]) begin
        ctrl_q <= '0;
      end else begin
        ctrl_q     <= ctrl_t'(wdata);
        ctrl_q.clr <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
    end else begin
      stat_q <= {busy_i, 4'b0000, present_i, wp_i, 1'b0};
    end
  end
endmodule

// File: rtl/nand_cycle_seq.sv
`timescale 1ns/1ps
module nand_cycle_seq #(
  parameter int BYTE_W    = 8,
  parameter int MAX_BYTES = 4,
  parameter int STROBE_LO = 2,
  parameter int STROBE_HI = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          abort,
  input  logic                          start,
  input  logic                          is_read,
  input  logic [IDX_W-1:0]              last_idx,
  input  logic [BYTE_W*MAX_BYTES-1:0]   wdata,
  input  logic [BYTE_W-1:0]             io_in,
  output logic                          we_n,
  output logic                          re_n,
  output logic [BYTE_W-1:0]             io_out,
  output logic                          io_oe,
  output logic [BYTE_W*MAX_BYTES-1:0]   rdata,
  output logic                          busy,
  output logic                          finish
);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int PH_N  = STROBE_LO + STROBE_HI;
  localparam int PH_W  = (PH_N > 1) ? $clog2(PH_N) : 1;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(STROBE_LO - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

  logic [PH_W-1:0]               phase;
  logic [IDX_W-1:0]              idx;
  logic [IDX_W-1:0]              idx_nx;
  logic [IDX_W-1:0]              last_q;
  logic                          dir_rd;
  logic [BYTE_W*MAX_BYTES-1:0]   wbuf;
  logic [BYTE_W-1:0]             nxt_byte;

  assign idx_nx = idx + 1'b1;
  assign finish = busy && (phase == PH_LAST) && (idx == last_q);

  always_comb begin
    nxt_byte = '0;
    for (int b = 0; b < MAX_BYTES; b++) begin
      if (idx_nx == IDX_W'(b)) nxt_byte = wbuf[b*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy   <= 1'b0;
      phase  <= '0;
      idx    <= '0;
      last_q <= '0;
      dir_rd <= 1'b0;
      wbuf   <= '0;
      rdata  <= '0;
      io_out <= '0;
      io_oe  <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        phase  <= '0;
        idx    <= '0;
        last_q <= last_idx;
        dir_rd <= is_read;
        wbuf   <= wdata;
        rdata  <= '0;
        io_out <= wdata[BYTE_W-1:0];
        io_oe  <= !is_read;
        we_n   <= is_read;
        re_n   <= !is_read;
      end
    end else begin
      if (phase == PH_RISE) begin
        we_n  <= 1'b1;
        re_n  <= 1'b1;
        phase <= phase + 1'b1;
        if (dir_rd) begin
          for (int b = 0; b < MAX_BYTES; b++) begin
            if (idx == IDX_W'(b)) rdata[b*BYTE_W +: BYTE_W] <= io_in;
          end
        end
      end else if (phase == PH_LAST) begin
        phase <= '0;
        if (idx == last_q) begin
          busy  <= 1'b0;
          io_oe <= 1'b0;
        end else begin
          idx    <= idx_nx;
          io_out <= nxt_byte;
          we_n   <= dir_rd;
          re_n   <= !dir_rd;
        end
      end else begin
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nand_port.sv
`timescale 1ns/1ps
module nand_port
  import nand_port_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int STROBE_LO = 2,
  parameter int STROBE_HI = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [1:0]        req_addr,
  input  logic              req_word,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic [BYTE_W-1:0] nand_io_out,
  output logic              nand_io_oe,
  input  logic [BYTE_W-1:0] nand_io_in,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_ce_n,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_wp_n,
  output logic              card_led,
  input  logic              card_busy,
  input  logic              card_present,
  input  logic              card_wp,
  output logic              ecc_en,
  input  logic [DATA_W-1:0] ecc_word,
  output logic              ecc_pop
);
  localparam int BYTES = DATA_W / BYTE_W;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  ctrl_t              ctrl_q;
  logic [7:0]         stat_q;
  reg_sel_e           sel;
  logic               accept, ecc_rd, seq_start, ctl_wr, imm_done;
  logic               seq_busy, seq_finish, pend_rd;
  logic [DATA_W-1:0]  seq_rdata;
  logic [IDX_W-1:0]   last_idx;

  assign sel       = reg_sel_e'(req_addr);
  assign accept    = req && !ready && !seq_busy;
  assign ecc_rd    = accept && (sel == SEL_DATA) && !req_wr && req_word && ctrl_q.ecc_acc;
  assign seq_start = accept && (sel == SEL_DATA) && !ecc_rd;
  assign ctl_wr    = accept && (sel == SEL_CTRL) && req_wr;
  assign imm_done  = accept && !seq_start;
  assign last_idx  = req_word ? IDX_W'(BYTES - 1) : '0;

  nand_ctl_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctl_wr),
    .wdata     (req_wdata[7:0]),
    .busy_i    (card_busy),
    .present_i (card_present),
    .wp_i      (card_wp),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q)
  );

  nand_cycle_seq #(
    .BYTE_W    (BYTE_W),
    .MAX_BYTES (BYTES),
    .STROBE_LO (STROBE_LO),
    .STROBE_HI (STROBE_HI)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .abort    (ctl_wr && req_wdata[CTRL_CLR_BIT]),
    .start    (seq_start),
    .is_read  (!req_wr),
    .last_idx (last_idx),
    .wdata    (req_wdata),
    .io_in    (nand_io_in),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .io_out   (nand_io_out),
    .io_oe    (nand_io_oe),
    .rdata    (seq_rdata),
    .busy     (seq_busy),
    .finish   (seq_finish)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready   <= 1'b0;
      rdata   <= '0;
      ecc_pop <= 1'b0;
      pend_rd <= 1'b0;
    end else begin
      ready   <= 1'b0;
      ecc_pop <= 1'b0;
      if (seq_start) pend_rd <= !req_wr;
      if (imm_done) begin
        ready <= 1'b1;
        unique case (sel)
          SEL_CTRL: rdata <= req_wr ? '0 : DATA_W'(ctrl_q);
          SEL_STAT: rdata <= req_wr ? '0 : DATA_W'(stat_q);
          SEL_DATA: begin
            rdata   <= ecc_word;
            ecc_pop <= 1'b1;
          end
          default:  rdata <= '0;
        endcase
      end else if (seq_finish) begin
        ready <= 1'b1;
        rdata <= pend_rd ? seq_rdata : '0;
      end
    end
  end

  assign nand_cle  = ctrl_q.cmd_latch;
  assign nand_ale  = ctrl_q.addr_latch;
  assign card_led  = ctrl_q.act;
  assign nand_ce_n = !ctrl_q.card_on;
  assign ecc_en    = ctrl_q.ecc_on;
  assign nand_wp_n = ctrl_q.wr_en;
endmodule

// File: rtl/nand_port_chk.sv
`timescale 1ns/1ps
module nand_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_wr,
  input logic [1:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic        ready,
  input logic        we_n,
  input logic        re_n,
  input logic        io_oe,
  input logic        cle,
  input logic        ale,
  input logic        ce_n,
  input logic        wp_n,
  input logic        ecc_pop
);
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !re_n));

  p_ready_single_r10: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  p_we_low_min_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(we_n) |=> !we_n);

  p_we_high_min_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |=> we_n);

  p_oe_on_write_r5: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> io_oe);

  p_no_oe_on_read_r6: assert property (@(posedge clk) disable iff (rst)
    !re_n |-> !io_oe);

  p_clear_bit_r3: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(req_wr && req_addr == 2'd1 && req_wdata[3]))
      |-> (!cle && !ale && ce_n && !wp_n));

  p_ecc_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    ecc_pop |-> (ready && we_n && re_n));
endmodule

bind nand_port nand_port_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_wr    (req_wr),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .ready     (ready),
  .we_n      (nand_we_n),
  .re_n      (nand_re_n),
  .io_oe     (nand_io_oe),
  .cle       (nand_cle),
  .ale       (nand_ale),
  .ce_n      (nand_ce_n),
  .wp_n      (nand_wp_n),
  .ecc_pop   (ecc_pop)
);

// File: tb/tb_nand_port.sv
`timescale 1ns/1ps
module tb_nand_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, req_wr = 1'b0, req_word = 1'b0;
  logic [1:0]  req_addr = 2'd0;
  logic [31:0] req_wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  logic [7:0]  nand_io_out, nand_io_in = 8'h00;
  logic        nand_io_oe, nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n, nand_wp_n;
  logic        card_led, ecc_en, ecc_pop;
  logic        card_busy = 1'b0, card_present = 1'b0, card_wp = 1'b0;
  logic [31:0] ecc_word = 32'hA5C3_1E7B;

  int n_checks = 0, n_err = 0;
  int wr_cnt = 0, re_cnt = 0, rd_idx = 0, pop_cnt = 0, strobe_bad = 0;
  int we_w = 0, re_w = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  logic [7:0] wr_log [8];
  logic [7:0] rd_src [4];
  bit finished = 0;

  always #2.5 clk = ~clk;

  nand_port dut (.*);

  // Card model and strobe monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (ecc_pop) pop_cnt++;
    if (!nand_we_n) we_w++;
    else if (!prev_we) begin
      if (we_w != 2 || !nand_io_oe) strobe_bad++;
      wr_log[wr_cnt % 8] = nand_io_out;
      wr_cnt++;
      we_w = 0;
    end
    if (!nand_re_n) begin
      if (prev_re) begin
        nand_io_in = rd_src[rd_idx % 4];
        rd_idx++;
      end
      if (nand_io_oe) strobe_bad++;
      re_w++;
    end else if (!prev_re) begin
      if (re_w != 2) strobe_bad++;
      re_cnt++;
      re_w = 0;
    end
    prev_we = nand_we_n;
    prev_re = nand_re_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [31:0] src, input bit word);
    return word ? src : {24'h0, src[7:0]};
  endfunction

  function automatic int exp_lat(input bit word);
    return word ? 17 : 5;
  endfunction

  task automatic acc(input logic wr, input logic [1:0] a, input logic word,
                     input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    req = 1'b1; req_wr = wr; req_addr = a; req_word = word; req_wdata = wd;
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (ready || lat > 100) break;
    end
    rd = rdata;
    req = 1'b0;
  endtask

  task automatic data_op(input string tag, input bit wr, input bit word,
                         input logic [31:0] val, input bit ecc_mode);
    logic [31:0] rd;
    int lat, wbase, rbase, sbase, n;
    n = word ? 4 : 1;
    wbase = wr_cnt; rbase = re_cnt; sbase = strobe_bad;
    for (int i = 0; i < 4; i++) rd_src[(rd_idx + i) % 4] = val[i*8 +: 8];
    acc(wr, 2'd0, word, val, rd, lat);
    chk({tag, " latency"}, lat, exp_lat(word));
    chk({tag, " strobe shape"}, strobe_bad - sbase, 0);
    if (wr) begin
      chk({tag, " write count"}, wr_cnt - wbase, n);
      for (int i = 0; i < n; i++)
        chk({tag, " byte order"}, wr_log[(wbase + i) % 8], val[i*8 +: 8]);
    end else begin
      chk({tag, " read count"}, re_cnt - rbase, n);
      chk({tag, ecc_mode ? " byte read in ecc mode" : " read data"}, rd, exp_read(val, word));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, v;
    int lat, sw, sr, sp;
    void'($urandom(32'h0BAD_5EED));
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", ready, 0);
    chk("R1 strobes", {nand_we_n, nand_re_n, nand_io_oe}, 3'b110);
    chk("R1 latches/enables", {nand_cle, nand_ale, nand_ce_n, nand_wp_n, ecc_pop}, 5'b00100);
    acc(1'b0, 2'd1, 1'b0, 0, rd, lat);
    chk("R1 ctrl readback", rd, 0);
    chk("R2 ctrl latency", lat, 1);

    // R2 control map
    acc(1'b1, 2'd1, 1'b0, 32'h0000_00F7, rd, lat);
    @(negedge clk);
    chk("R2 outputs", {nand_wp_n, ecc_en, nand_ce_n, card_led, nand_ale, nand_cle}, 6'b110111);
    acc(1'b0, 2'd1, 1'b0, 0, rd, lat);
    chk("R2 readback", rd, 32'hF7);
    acc(1'b1, 2'd1, 1'b0, 32'h0000_0025, rd, lat);
    @(negedge clk);
    chk("R2 outputs 2", {nand_wp_n, ecc_en, nand_ce_n, card_led, nand_ale, nand_cle}, 6'b011101);

    // R3 clear bit
    acc(1'b1, 2'd1, 1'b0, 32'h0000_00FF, rd, lat);
    @(negedge clk);
    chk("R3 outputs", {nand_ce_n, nand_wp_n, nand_cle, nand_ale, ecc_en}, 5'b10000);
    acc(1'b0, 2'd1, 1'b0, 0, rd, lat);
    chk("R3 readback", rd, 0);

    // R9 status
    card_busy = 1'b1; card_present = 1'b1; card_wp = 1'b0;
    repeat (2) @(negedge clk);
    acc(1'b0, 2'd2, 1'b0, 0, rd, lat);
    chk("R9 status busy+present", rd, 32'h84);
    card_busy = 1'b0; card_present = 1'b0; card_wp = 1'b1;
    repeat (2) @(negedge clk);
    acc(1'b0, 2'd2, 1'b0, 0, rd, lat);
    chk("R9 status wp", rd, 32'h02);

    // enable card and writes
    acc(1'b1, 2'd1, 1'b0, 32'h90, rd, lat);
    data_op("R4 byte write", 1'b1, 1'b0, 32'hDEAD_BE5A, 1'b0);
    data_op("R5 word write", 1'b1, 1'b1, 32'h4433_2211, 1'b0);
    data_op("R6 byte read", 1'b0, 1'b0, 32'hFFFF_FF3C, 1'b0);
    data_op("R7 word read", 1'b0, 1'b1, 32'h8877_6655, 1'b0);

    // R8 ecc access
    acc(1'b1, 2'd1, 1'b0, 32'hF0, rd, lat);
    sw = wr_cnt; sr = re_cnt; sp = pop_cnt;
    acc(1'b0, 2'd0, 1'b1, 0, rd, lat);
    @(negedge clk);
    chk("R8 ecc word", rd, ecc_word);
    chk("R8 ecc latency", lat, 1);
    chk("R8 no strobe", (wr_cnt - sw) + (re_cnt - sr), 0);
    chk("R8 pop pulses", pop_cnt - sp, 1);
    data_op("R8", 1'b0, 1'b0, 32'h0000_00C9, 1'b1);
    acc(1'b1, 2'd1, 1'b0, 32'h90, rd, lat);

    // random mix, R4-R7 and R10
    for (int k = 0; k < 40; k++) begin
      v = $urandom;
      case ($urandom % 4)
        0: data_op("R4 rnd byte write", 1'b1, 1'b0, v, 1'b0);
        1: data_op("R5 rnd word write", 1'b1, 1'b1, v, 1'b0);
        2: data_op("R6 rnd byte read", 1'b0, 1'b0, v, 1'b0);
        default: data_op("R7 rnd word read R10", 1'b0, 1'b1, v, 1'b0);
      endcase
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule